// File: doc/BRIEF.md
# Multi-Queue Command Dispatcher

This block stands between a set of host command queues and two downstream engines: a compute engine that runs kernel launches and a copy engine that moves data between host and device memory. It looks only at the head entry of each host queue. It decodes a 2-bit kind field there and offers each command to the matching engine's input queue, tagged with the index of the queue it came from.

Once a queue has handed over a command, it is locked. Its head is not considered again until the engine that took the command reports completion with that queue's tag. Each queue therefore runs strictly in order. Different queues can keep both engines busy at the same time. Within each engine, eligible queues share access by round-robin. A full engine queue pushes back: the head stays where it is until the engine accepts it.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset no queue is locked, both round-robin pointers sit at queue 0, and with no head valid nothing is offered or popped.
- R2: A head of kind 0 (kernel launch) on an unlocked queue is offered on the compute port with its payload, and `ex_tag` names the source queue. The compute port never carries any other kind.
- R3: Heads of kind 1 (host-to-device copy) and kind 2 (device-to-host copy) on unlocked queues are offered on the copy port, with `dma_kind` equal to the kind, plus the payload and the tag.
- R4: Each engine takes at most one command per cycle. Among its requesters, the winner is the first one at or after the queue that follows the last winner on that engine, wrapping past the highest index.
- R5: `q_ready[i]` is high only in the cycle where queue i's head is taken. While an engine holds its ready low, the offered head is not popped and that engine's pointer does not move.
- R6: From the cycle after a command is taken, its queue is locked: the queue's head is neither offered nor popped while the lock holds.
- R7: A completion whose tag names an unlocked queue, or a queue locked by the other engine, changes nothing.
- R8: A head of kind 3 (reserved) on an unlocked queue is dropped: it is popped in the same cycle, goes to no engine and leaves the queue unlocked.
- R9: A completion from the engine that holds a queue's lock reopens that queue, and its next head can be taken in the following cycle.
- R10: A kernel launch from one queue and a copy from another queue can both be taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | NQ | Head of queue i is present |
| q_kind | input | 2*NQ | Kind field of each head, queue i at bits [2i+1:2i] |
| q_payload | input | PW*NQ | Payload of each head, queue i at slice i |
| q_ready | output | NQ | Head of queue i is taken this cycle |
| ex_valid | output | 1 | Compute port offer |
| ex_ready | input | 1 | Compute engine queue can accept |
| ex_tag | output | log2(NQ) | Source queue of the compute offer |
| ex_payload | output | PW | Payload of the compute offer |
| dma_valid | output | 1 | Copy port offer |
| dma_ready | input | 1 | Copy engine queue can accept |
| dma_tag | output | log2(NQ) | Source queue of the copy offer |
| dma_kind | output | 2 | Copy direction (1 or 2) |
| dma_payload | output | PW | Payload of the copy offer |
| ex_done | input | 1 | Compute engine completion |
| ex_done_tag | input | log2(NQ) | Queue tag of that completion |
| dma_done | input | 1 | Copy engine completion |
| dma_done_tag | input | log2(NQ) | Queue tag of that completion |

## Verification
The hardest case to reach from the ports is a completion that names a queue locked by the other engine. A correct engine never sends one. It must arrive while that queue still holds a valid head, or the missing reopen cannot be seen. The bench keeps per-queue backlogs, so locked queues usually have a head waiting, and it mixes stray completions with random tags into real ones. The reference model decides which completions count and compares the offers and pops on every cycle. Engine ready is also withheld at random, so held heads and frozen pointers occur alongside reopenings.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_KERNEL = 2'd0,
    KIND_H2D    = 2'd1,
    KIND_D2H    = 2'd2,
    KIND_RSVD   = 2'd3
  } cmd_kind_e;

  function automatic logic kind_is_copy(input cmd_kind_e k);
    return (k == KIND_H2D) || (k == KIND_D2H);
  endfunction

endpackage

// File: rtl/cd_head_decode.sv
module cd_head_decode
  import cmd_dispatch_pkg::*;
(
  input  logic              head_valid,
  input  logic [KIND_W-1:0] head_kind,
  input  logic              locked,
  output logic              want_ex,
  output logic              want_dma,
  output logic              want_drop
);
  cmd_kind_e kind;
  logic      open;

  always_comb begin
    kind      = cmd_kind_e'(head_kind);
    open      = head_valid && !locked;
    want_ex   = open && (kind == KIND_KERNEL);
    want_dma  = open && kind_is_copy(kind);
    want_drop = open && (kind == KIND_RSVD);
  end
endmodule

// File: rtl/cd_rr_arbiter.sv
module cd_rr_arbiter #(
  parameter int NQ = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NQ-1:0]           req,
  input  logic                    advance,
  output logic [$clog2(NQ)-1:0]   grant_idx,
  output logic                    grant_any
);
  localparam int IW = $clog2(NQ);

  logic [IW-1:0] ptr_q;

  // Rotate the request vector so the pointer lands at bit 0, take the
  // lowest set bit, then rotate the index back.
  function automatic logic [IW:0] rr_pick(input logic [NQ-1:0] r,
                                          input logic [IW-1:0] p);
    logic [2*NQ-1:0] dbl;
    logic [NQ-1:0]   rot;
    logic [IW:0]     res;
    int              s;
    dbl = {r, r} >> p;
    rot = dbl[NQ-1:0];
    res = '0;
    for (int k = NQ - 1; k >= 0; k--) begin
      if (rot[k]) begin
        s = k + int'(p);
        if (s >= NQ) s = s - NQ;
        res = {1'b1, IW'(s)};
      end
    end
    return res;
  endfunction

  logic [IW:0] pick;

  always_comb begin
    pick      = rr_pick(req, ptr_q);
    grant_any = pick[IW];
    grant_idx = pick[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance && grant_any) begin
      ptr_q <= (int'(grant_idx) == NQ - 1) ? '0 : grant_idx + 1'b1;
    end
  end
endmodule

// File: rtl/cd_lock_table.sv
module cd_lock_table #(
  parameter int NQ = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_ex,
  input  logic [$clog2(NQ)-1:0] take_ex_idx,
  input  logic                  take_dma,
  input  logic [$clog2(NQ)-1:0] take_dma_idx,
  input  logic                  ex_done,
  input  logic [$clog2(NQ)-1:0] ex_done_tag,
  input  logic                  dma_done,
  input  logic [$clog2(NQ)-1:0] dma_done_tag,
  output logic [NQ-1:0]         locked,
  output logic [NQ-1:0]         on_dma,
  output logic [NQ-1:0]         reopen
);
  for (genvar i = 0; i < NQ; i++) begin : g_slot
    logic hit_ex_done, hit_dma_done, set_ex, set_dma;

    always_comb begin
      hit_ex_done  = ex_done  && (int'(ex_done_tag)  == i) && !on_dma[i];
      hit_dma_done = dma_done && (int'(dma_done_tag) == i) &&  on_dma[i];
      reopen[i]    = locked[i] && (hit_ex_done || hit_dma_done);
      set_ex       = take_ex  && (int'(take_ex_idx)  == i);
      set_dma      = take_dma && (int'(take_dma_idx) == i);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        locked[i] <= 1'b0;
        on_dma[i] <= 1'b0;
      end else if (set_ex) begin
        locked[i] <= 1'b1;
        on_dma[i] <= 1'b0;
      end else if (set_dma) begin
        locked[i] <= 1'b1;
        on_dma[i] <= 1'b1;
      end else if (reopen[i]) begin
        locked[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_dispatch_pkg::*;
#(
  parameter int NQ = 8,
  parameter int PW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NQ-1:0]          q_valid,
  input  logic [2*NQ-1:0]        q_kind,
  input  logic [PW*NQ-1:0]       q_payload,
  output logic [NQ-1:0]          q_ready,
  output logic                   ex_valid,
  input  logic                   ex_ready,
  output logic [$clog2(NQ)-1:0]  ex_tag,
  output logic [PW-1:0]          ex_payload,
  output logic                   dma_valid,
  input  logic                   dma_ready,
  output logic [$clog2(NQ)-1:0]  dma_tag,
  output logic [1:0]             dma_kind,
  output logic [PW-1:0]          dma_payload,
  input  logic                   ex_done,
  input  logic [$clog2(NQ)-1:0]  ex_done_tag,
  input  logic                   dma_done,
  input  logic [$clog2(NQ)-1:0]  dma_done_tag
);
  localparam int IW = $clog2(NQ);

  // Named internal events, also watched by the bound checker.
  logic [NQ-1:0] locked_q, lock_dma_q, reopen;
  logic [NQ-1:0] req_ex, req_dma, req_drop;
  logic [IW-1:0] ex_idx, dma_idx;
  logic          ex_any, dma_any, ex_fire, dma_fire;

  for (genvar i = 0; i < NQ; i++) begin : g_head
    cd_head_decode u_dec (
      .head_valid (q_valid[i]),
      .head_kind  (q_kind[i*KIND_W +: KIND_W]),
      .locked     (locked_q[i]),
      .want_ex    (req_ex[i]),
      .want_dma   (req_dma[i]),
      .want_drop  (req_drop[i])
    );
  end

  cd_rr_arbiter #(.NQ(NQ)) u_arb_ex (
    .clk(clk), .rst_n(rst_n), .req(req_ex), .advance(ex_fire),
    .grant_idx(ex_idx), .grant_any(ex_any)
  );

  cd_rr_arbiter #(.NQ(NQ)) u_arb_dma (
    .clk(clk), .rst_n(rst_n), .req(req_dma), .advance(dma_fire),
    .grant_idx(dma_idx), .grant_any(dma_any)
  );

  always_comb begin
    ex_valid    = ex_any;
    ex_tag      = ex_idx;
    ex_payload  = q_payload[int'(ex_idx)*PW +: PW];
    dma_valid   = dma_any;
    dma_tag     = dma_idx;
    dma_kind    = q_kind[int'(dma_idx)*KIND_W +: KIND_W];
    dma_payload = q_payload[int'(dma_idx)*PW +: PW];
    ex_fire     = ex_any && ex_ready;
    dma_fire    = dma_any && dma_ready;
    for (int i = 0; i < NQ; i++) begin
      q_ready[i] = req_drop[i]
                 || (ex_fire  && (int'(ex_idx)  == i))
                 || (dma_fire && (int'(dma_idx) == i));
    end
  end

  cd_lock_table #(.NQ(NQ)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .take_ex(ex_fire), .take_ex_idx(ex_idx),
    .take_dma(dma_fire), .take_dma_idx(dma_idx),
    .ex_done(ex_done), .ex_done_tag(ex_done_tag),
    .dma_done(dma_done), .dma_done_tag(dma_done_tag),
    .locked(locked_q), .on_dma(lock_dma_q), .reopen(reopen)
  );
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk
  import cmd_dispatch_pkg::*;
#(
  parameter int NQ = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NQ-1:0]         q_valid,
  input logic [2*NQ-1:0]       q_kind,
  input logic [NQ-1:0]         q_ready,
  input logic                  ex_valid,
  input logic                  ex_ready,
  input logic [$clog2(NQ)-1:0] ex_tag,
  input logic                  dma_valid,
  input logic                  dma_ready,
  input logic [$clog2(NQ)-1:0] dma_tag,
  input logic [1:0]            dma_kind,
  input logic                  ex_done,
  input logic [$clog2(NQ)-1:0] ex_done_tag,
  input logic                  dma_done,
  input logic [$clog2(NQ)-1:0] dma_done_tag,
  input logic [NQ-1:0]         locked_q,
  input logic [NQ-1:0]         lock_dma_q,
  input logic [NQ-1:0]         req_ex,
  input logic [NQ-1:0]         req_dma,
  input logic [NQ-1:0]         req_drop
);
  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> locked_q == '0); // R1
  AST_EX_ONLY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n) ex_valid |-> (q_kind[int'(ex_tag)*2 +: 2] == KIND_KERNEL) && q_valid[ex_tag] && !locked_q[ex_tag]); // R2
  AST_DMA_ONLY_COPY: assert property (@(posedge clk) disable iff (!rst_n) dma_valid |-> (dma_kind == 2'd1 || dma_kind == 2'd2) && q_valid[dma_tag] && !locked_q[dma_tag]); // R3
  AST_ONE_EX_TAKE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_ready & req_ex)); // R4
  AST_ONE_DMA_TAKE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_ready & req_dma)); // R4
  AST_EX_HELD: assert property (@(posedge clk) disable iff (!rst_n) ex_valid && !ex_ready |-> !q_ready[ex_tag]); // R5
  AST_DMA_HELD: assert property (@(posedge clk) disable iff (!rst_n) dma_valid && !dma_ready |-> !q_ready[dma_tag]); // R5
  AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (q_ready & locked_q) == '0); // R6
  AST_EX_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) ex_valid && ex_ready |=> locked_q[$past(ex_tag)] && !lock_dma_q[$past(ex_tag)]); // R6
  AST_DMA_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) dma_valid && dma_ready |=> locked_q[$past(dma_tag)] && lock_dma_q[$past(dma_tag)]); // R6
  AST_STRAY_EX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_done && !(locked_q[ex_done_tag] && !lock_dma_q[ex_done_tag]) && !q_ready[ex_done_tag]
      && !(dma_done && dma_done_tag == ex_done_tag)
    |=> locked_q[$past(ex_done_tag)] == $past(locked_q[ex_done_tag])); // R7
  AST_DROP_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (locked_q & $past(q_ready & req_drop)) == '0); // R8
endmodule

bind cmd_dispatch cmd_dispatch_chk #(.NQ(NQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_kind(q_kind), .q_ready(q_ready),
  .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_tag(ex_tag),
  .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_tag(dma_tag), .dma_kind(dma_kind),
  .ex_done(ex_done), .ex_done_tag(ex_done_tag), .dma_done(dma_done), .dma_done_tag(dma_done_tag),
  .locked_q(locked_q), .lock_dma_q(lock_dma_q),
  .req_ex(req_ex), .req_dma(req_dma), .req_drop(req_drop)
);

// File: tb/cmd_dispatch_tb_top.sv
module cmd_dispatch_tb_top;
  localparam int NQ = 8;
  localparam int PW = 32;
  localparam int IW = 3;
  localparam int RUN_CYCLES = 4000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [NQ-1:0]    q_valid;
  logic [2*NQ-1:0]  q_kind;
  logic [PW*NQ-1:0] q_payload;
  logic [NQ-1:0]    q_ready;
  logic             ex_valid, ex_ready, dma_valid, dma_ready;
  logic [IW-1:0]    ex_tag, dma_tag, ex_done_tag, dma_done_tag;
  logic [PW-1:0]    ex_payload, dma_payload;
  logic [1:0]       dma_kind;
  logic             ex_done, dma_done;

  cmd_dispatch #(.NQ(NQ), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_kind(q_kind), .q_payload(q_payload),
    .q_ready(q_ready), .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_tag(ex_tag),
    .ex_payload(ex_payload), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_tag(dma_tag), .dma_kind(dma_kind), .dma_payload(dma_payload),
    .ex_done(ex_done), .ex_done_tag(ex_done_tag), .dma_done(dma_done),
    .dma_done_tag(dma_done_tag)
  );

  typedef struct packed { logic [1:0] k; logic [PW-1:0] p; } cmd_t;

  cmd_t hq [NQ][$];
  bit   m_lock [NQ];
  bit   m_dma  [NQ];
  int   m_pex, m_pdma;
  int   ex_fly[$], dma_fly[$];
  int   n_chk, n_fail;
  int   cov_conc, cov_drop, cov_stray, cov_reopen;
  bit   finished;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rr_model(input bit r[NQ], input int ptr);
    for (int k = 0; k < NQ; k++) begin
      if (r[(ptr + k) % NQ]) return (ptr + k) % NQ;
    end
    return -1;
  endfunction

  function automatic bool_done_real(input int tag, input bit on_copy);
    return m_lock[tag] && (m_dma[tag] == on_copy);
  endfunction

  initial begin
    rst_n = 1'b0; q_valid = '0; q_kind = '0; q_payload = '0;
    ex_ready = 1'b0; dma_ready = 1'b0; ex_done = 1'b0; dma_done = 1'b0;
    ex_done_tag = '0; dma_done_tag = '0;
    n_chk = 0; n_fail = 0; m_pex = 0; m_pdma = 0; finished = 0;
    cov_conc = 0; cov_drop = 0; cov_stray = 0; cov_reopen = 0;
    for (int i = 0; i < NQ; i++) begin m_lock[i] = 0; m_dma[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "ex_valid in reset", ex_valid, 0);
    check("R1", "dma_valid in reset", dma_valid, 0);
    check("R1", "q_ready in reset", q_ready, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "ex_valid idle", ex_valid, 0);
    check("R1", "q_ready idle", q_ready, 0);

    begin
      string ctx;
      ctx = "R5";
      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
        bit rq_ex[NQ], rq_dma[NQ], rq_drop[NQ];
        bit exp_rdy[NQ];
        int gx, gd;
        bit real_done, stray;
        @(negedge clk);
        // refill backlogs; a head never changes until popped
        for (int i = 0; i < NQ; i++) begin
          if (hq[i].size() < 6 && ($urandom % 4) == 0) begin
            cmd_t c;
            int r;
            r = $urandom % 8;
            c.k = (r < 3) ? 2'd0 : (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
            c.p = $urandom;
            hq[i].push_back(c);
          end
        end
        for (int i = 0; i < NQ; i++) begin
          q_valid[i] = hq[i].size() > 0;
          q_kind[i*2 +: 2]      = q_valid[i] ? hq[i][0].k : 2'd0;
          q_payload[i*PW +: PW] = q_valid[i] ? hq[i][0].p : '0;
        end
        ex_ready  = ($urandom % 4) != 0;
        dma_ready = ($urandom % 4) != 0;
        real_done = 0; stray = 0;
        ex_done = 0; dma_done = 0;
        if (ex_fly.size() > 0 && ($urandom % 3) == 0) begin
          ex_done = 1; ex_done_tag = IW'(ex_fly[$urandom % ex_fly.size()]);
        end else if (($urandom % 6) == 0) begin
          ex_done = 1; ex_done_tag = IW'($urandom % NQ);
        end
        if (dma_fly.size() > 0 && ($urandom % 3) == 0) begin
          dma_done = 1; dma_done_tag = IW'(dma_fly[$urandom % dma_fly.size()]);
        end else if (($urandom % 6) == 0) begin
          dma_done = 1; dma_done_tag = IW'($urandom % NQ);
        end
        if (ex_done) begin
          if (bool_done_real(int'(ex_done_tag), 0)) real_done = 1; else stray = 1;
        end
        if (dma_done) begin
          if (bool_done_real(int'(dma_done_tag), 1)) real_done = 1; else stray = 1;
        end
        // expected offers from the model state
        for (int i = 0; i < NQ; i++) begin
          bit open;
          open = q_valid[i] && !m_lock[i];
          rq_ex[i]   = open && hq[i][0].k == 2'd0;
          rq_dma[i]  = open && (hq[i][0].k == 2'd1 || hq[i][0].k == 2'd2);
          rq_drop[i] = open && hq[i][0].k == 2'd3;
        end
        gx = rr_model(rq_ex, m_pex);
        gd = rr_model(rq_dma, m_pdma);
        for (int i = 0; i < NQ; i++)
          exp_rdy[i] = rq_drop[i] || (gx == i && ex_ready) || (gd == i && dma_ready);
        #1;
        check("R2", "ex_valid", ex_valid, gx >= 0);
        if (gx >= 0) begin
          check("R4", "ex_tag", ex_tag, gx);
          check("R2", "ex_payload", ex_payload, hq[gx][0].p);
        end
        check("R3", "dma_valid", dma_valid, gd >= 0);
        if (gd >= 0) begin
          check("R4", "dma_tag", dma_tag, gd);
          check("R3", "dma_kind", dma_kind, hq[gd][0].k);
          check("R3", "dma_payload", dma_payload, hq[gd][0].p);
        end
        for (int i = 0; i < NQ; i++) begin
          if (q_valid[i] && m_lock[i]) check("R6", "q_ready of locked queue", q_ready[i], 0);
          else if (rq_drop[i]) check("R8", "q_ready of reserved head", q_ready[i], 1);
          else check(ctx, $sformatf("q_ready[%0d]", i), q_ready[i], exp_rdy[i]);
        end
        if (gx >= 0 && gd >= 0 && ex_ready && dma_ready) begin
          cov_conc++;
          check("R10", "both ports taken", {ex_valid && ex_ready, dma_valid && dma_ready}, 2'b11);
        end
        @(posedge clk);
        // advance the model
        for (int i = 0; i < NQ; i++) begin
          if (exp_rdy[i]) begin
            void'(hq[i].pop_front());
            if (rq_drop[i]) cov_drop++;
          end
        end
        if (ex_done && bool_done_real(int'(ex_done_tag), 0)) begin
          m_lock[ex_done_tag] = 0;
          for (int j = 0; j < ex_fly.size(); j++)
            if (ex_fly[j] == int'(ex_done_tag)) begin ex_fly.delete(j); break; end
          cov_reopen++;
        end
        if (dma_done && bool_done_real(int'(dma_done_tag), 1)) begin
          m_lock[dma_done_tag] = 0;
          for (int j = 0; j < dma_fly.size(); j++)
            if (dma_fly[j] == int'(dma_done_tag)) begin dma_fly.delete(j); break; end
          cov_reopen++;
        end
        if (gx >= 0 && ex_ready) begin
          m_lock[gx] = 1; m_dma[gx] = 0; ex_fly.push_back(gx); m_pex = (gx + 1) % NQ;
        end
        if (gd >= 0 && dma_ready) begin
          m_lock[gd] = 1; m_dma[gd] = 1; dma_fly.push_back(gd); m_pdma = (gd + 1) % NQ;
        end
        if (stray) cov_stray++;
        ctx = stray ? "R7" : (real_done ? "R9" : "R5");
      end
    end
    check("R7", "stray completions exercised", cov_stray > 0, 1);
    check("R8", "reserved heads dropped", cov_drop > 0, 1);
    check("R9", "queues reopened", cov_reopen > 0, 1);
    check("R10", "concurrent issue seen", cov_conc > 0, 1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule